// File: doc/BRIEF.md
# Interrupt distributor control registers

This block is the small 32-bit register slave that answers for the global words of an interrupt distributor. It serves three words: a control word that holds the distributor's master enable, a read-only type word that reports how many interrupt lines and processors the distributor serves, and a read-only identification word that carries fixed product and implementer codes. A pulse asking every CPU to re-examine its interrupt state is produced when the master enable is switched on.

The same slave also judges every access to the distributor's 4 KiB register map. It checks that each access is word-aligned and that its offset falls inside one of the map's regions. The length of each per-interrupt region follows the live interrupt count. Accesses use single-cycle read and write strobes with a 12-bit byte offset. The read data and the error flag are registered and appear in the cycle after the strobe. The processor count and the shared-interrupt count are static inputs.

Top module: `irqdist_ctl_regs`

## Requirements
- R1: After reset `glob_en`, `wake_all`, `acc_err` are 0 and `rdata` is zero.
- R2: A read strobe at offset 0x000 returns `{31'b0, enable}` on `rdata` in the cycle after the strobe. `rdata` is zero in every cycle that follows a cycle without a read strobe.
- R3: A write strobe at offset 0x000 loads the enable from `wdata[0]`. `glob_en` shows the new value from the cycle after the strobe.
- R4: `wake_all` is high for exactly the one cycle after a control write that takes the enable from 0 to 1. It stays low for a write that leaves the enable at 1 or clears it.
- R5: A read at offset 0x004 returns the type word. Bits [4:0] hold (shared + 32)/32 − 1 and bits [7:5] hold `cpu_count` − 1. All other bits are zero.
- R6: A read at offset 0x008 returns the identification word. Bits [31:24] hold the product code (default 0xA5) and bits [11:0] hold the implementer code (default 0x3C1). All other bits are zero, so the default word is 0xA50003C1.
- R7: Writes to offsets 0x004 and 0x008 have no effect: the enable, the wake pulse and both read-only words are unchanged.
- R8: An access whose offset has bits [1:0] ≠ 0 raises `acc_err` in the cycle after the strobe. Such a write does not change the enable, and such a read returns zero.
- R9: An aligned access outside every region raises `acc_err` in the next cycle. An aligned access inside a region does not, and it reads zero unless it targets a control-window word. The regions are as follows, with total = shared + 32. The control window is 0x000 with 12 bytes. The 1-bit-per-interrupt regions start at 0x080, 0x100, 0x180, 0x200, 0x280, 0x300 and 0x380. The 8-bit regions start at 0x400 and 0x800, and the 2-bit region starts at 0xC00. Each per-interrupt region is bits × total / 8 bytes long. The fixed regions are 0xF00 with 4 bytes, and 0xF10 and 0xF20 with 16 bytes each.
- R10: A read and a write strobe to offset 0x000 in the same cycle return the enable value from before the write, while the write still takes effect and may raise `wake_all`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| addr | input | 12 | Byte offset into the distributor map |
| wdata | input | 32 | Write data |
| spi_count | input | SPI_W (10) | Number of shared interrupts, a multiple of 32 |
| cpu_count | input | CPU_W+1 (4) | Number of online processors, 1 to 8 |
| rdata | output | 32 | Read data, valid the cycle after `rd_stb` |
| glob_en | output | 1 | Distributor master enable level |
| wake_all | output | 1 | One-cycle pulse on a 0-to-1 change of the enable |
| acc_err | output | 1 | Misaligned or unmapped access, the cycle after the strobe |

## Verification
A control read and a control write can fall in the same cycle. In that cycle the read must return the enable held before the edge, while the write updates the enable and may fire the wake pulse. The bench raises both strobes together at offset 0x000, first with the enable clear and write data 1, then with the enable set and write data 0. It then checks that the returned word is the old enable, that `glob_en` is the new one, and that `wake_all` is high only for the rising case. The wake pulse and the error flag are also judged against each other, since a misaligned write carrying a 1 must flag an error and must not wake.

// File: rtl/irqdist_pkg.sv
package irqdist_pkg;

   // Number of regions in the distributor map
   localparam int NUM_RGN = 14;

   // Bytes covered by the global control window
   localparam int CTL_WIN = 12;

   typedef enum logic [1:0] {
      SEL_CTL  = 2'd0,
      SEL_TYP  = 2'd1,
      SEL_IID  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   // Region start offsets
   localparam logic [11:0] RGN_BASE [NUM_RGN] = '{
      12'h000,                                     // control window
      12'h080, 12'h100, 12'h180, 12'h200,          // one bit per line
      12'h280, 12'h300, 12'h380,
      12'h400, 12'h800,                            // one byte per line
      12'hC00,                                     // two bits per line
      12'hF00, 12'hF10, 12'hF20                    // fixed software words
   };

   // Bits per interrupt line, 0 for a fixed-length region
   localparam int RGN_BPI [NUM_RGN] = '{
      0, 1, 1, 1, 1, 1, 1, 1, 8, 8, 2, 0, 0, 0
   };

   // Byte length of the fixed-length regions
   localparam int RGN_LEN [NUM_RGN] = '{
      CTL_WIN, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4, 16, 16
   };

   function automatic reg_sel_e decode_sel(input logic [11:0] off);
      if (off < 12'(CTL_WIN) && off[1:0] == 2'b00)
         return reg_sel_e'(off[3:2]);
      return SEL_NONE;
   endfunction

endpackage

// File: rtl/irqdist_range_chk.sv
module irqdist_range_chk
   import irqdist_pkg::*;
#(
   parameter int SPI_W = 10
) (
   input  logic [11:0]      addr,
   input  logic [SPI_W-1:0] spi_count,
   output logic             aligned,
   output logic             in_map
);

   localparam int PROD_W = SPI_W + 4;
   localparam int SUM_W  = ((PROD_W > 12) ? PROD_W : 12) + 1;

   logic [SUM_W-1:0]   total;
   logic [SUM_W-1:0]   off_ext;
   logic [NUM_RGN-1:0] hit;

   assign total   = SUM_W'(spi_count) + SUM_W'(32);
   assign off_ext = SUM_W'(addr);
   assign aligned = (addr[1:0] == 2'b00);

   for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
      localparam logic [SUM_W-1:0] BASE_G = SUM_W'(RGN_BASE[g]);
      logic [SUM_W-1:0] len;
      if (RGN_BPI[g] == 0) begin : g_fixed
         assign len = SUM_W'(RGN_LEN[g]);
      end else begin : g_scaled
         assign len = (total * SUM_W'(RGN_BPI[g])) >> 3;
      end
      assign hit[g] = (off_ext >= BASE_G) && (off_ext < BASE_G + len);
   end

   assign in_map = |hit;

   if (SPI_W < 5 || SPI_W > 12) begin : g_bad_spi_w
      $error("irqdist_range_chk: SPI_W must lie in 5..12");
   end

endmodule

// File: rtl/irqdist_rd_fmt.sv
module irqdist_rd_fmt
   import irqdist_pkg::*;
#(
   parameter int          SPI_W     = 10,
   parameter int          CPU_W     = 3,
   parameter logic [7:0]  PROD_CODE = 8'hA5,
   parameter logic [11:0] IMPL_CODE = 12'h3C1
) (
   input  reg_sel_e         sel,
   input  logic             en,
   input  logic [SPI_W-1:0] spi_count,
   input  logic [CPU_W:0]   cpu_count,
   output logic [31:0]      word
);

   logic [SPI_W:0] total;
   logic [31:0]    typ_word;
   logic [31:0]    iid_word;

   assign total    = (SPI_W+1)'(spi_count) + (SPI_W+1)'(32);
   assign typ_word = {24'h0, 3'(cpu_count - 1'b1), 5'((total >> 5) - 1'b1)};
   assign iid_word = {PROD_CODE, 12'h000, IMPL_CODE};

   always_comb begin
      unique case (sel)
         SEL_CTL: word = {31'h0, en};
         SEL_TYP: word = typ_word;
         SEL_IID: word = iid_word;
         default: word = 32'h0;
      endcase
   end

endmodule

// File: rtl/irqdist_ctl_core.sv
module irqdist_ctl_core (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_ok,
   input  logic wbit,
   output logic glob_en,
   output logic wake_all
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glob_en  <= 1'b0;
         wake_all <= 1'b0;
      end else begin
         wake_all <= wr_ok && wbit && !glob_en;
         if (wr_ok)
            glob_en <= wbit;
      end
   end

   // R4: a pulse only follows a rise of the enable
   p_wake_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wake_all |-> (glob_en && !$past(glob_en)));

   // R4: never two pulses back to back
   p_wake_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wake_all |=> !wake_all);

   // R3: the enable only moves on an accepted control write
   p_en_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ok |=> $stable(glob_en));

endmodule

// File: rtl/irqdist_ctl_regs.sv
module irqdist_ctl_regs
   import irqdist_pkg::*;
#(
   parameter int          SPI_W     = 10,
   parameter int          CPU_W     = 3,
   parameter logic [7:0]  PROD_CODE = 8'hA5,
   parameter logic [11:0] IMPL_CODE = 12'h3C1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_stb,
   input  logic             wr_stb,
   input  logic [11:0]      addr,
   input  logic [31:0]      wdata,
   input  logic [SPI_W-1:0] spi_count,
   input  logic [CPU_W:0]   cpu_count,
   output logic [31:0]      rdata,
   output logic             glob_en,
   output logic             wake_all,
   output logic             acc_err
);

   reg_sel_e    sel;
   logic        aligned;
   logic        in_map;
   logic        err_now;
   logic        wr_ok;
   logic [31:0] word;
   logic        unused_wdata;

   assign sel          = decode_sel(addr);
   assign wr_ok        = wr_stb && (sel == SEL_CTL);
   assign err_now      = (rd_stb || wr_stb) && (!aligned || !in_map);
   assign unused_wdata = ^wdata[31:1];

   irqdist_range_chk #(.SPI_W(SPI_W)) u_range (
      .addr      (addr),
      .spi_count (spi_count),
      .aligned   (aligned),
      .in_map    (in_map)
   );

   irqdist_rd_fmt #(
      .SPI_W     (SPI_W),
      .CPU_W     (CPU_W),
      .PROD_CODE (PROD_CODE),
      .IMPL_CODE (IMPL_CODE)
   ) u_fmt (
      .sel       (sel),
      .en        (glob_en),
      .spi_count (spi_count),
      .cpu_count (cpu_count),
      .word      (word)
   );

   irqdist_ctl_core u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ok    (wr_ok),
      .wbit     (wdata[0]),
      .glob_en  (glob_en),
      .wake_all (wake_all)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata   <= 32'h0;
         acc_err <= 1'b0;
      end else begin
         rdata   <= rd_stb ? word : 32'h0;
         acc_err <= err_now;
      end
   end

   if (CPU_W < 1 || CPU_W > 3) begin : g_bad_cpu_w
      $error("irqdist_ctl_regs: CPU_W must lie in 1..3");
   end

   // R8: misaligned strobes are flagged next cycle
   p_misalign_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_stb || wr_stb) && addr[1:0] != 2'b00) |=> acc_err);

   // R2: no read strobe, no read data
   p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> (rdata == 32'h0));

   // R7: writes away from the control word leave the enable alone
   p_ro_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && addr != 12'h000) |=> ($stable(glob_en) && !wake_all));

   // R9: idle cycles never raise the error flag
   p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_stb || wr_stb) |=> !acc_err);

endmodule

// File: tb/sim_irqdist_ctl_regs.sv
module sim_irqdist_ctl_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_stb = 1'b0;
   logic        wr_stb = 1'b0;
   logic [11:0] addr = 12'h0;
   logic [31:0] wdata = 32'h0;
   logic [9:0]  spi_count = 10'd32;
   logic [3:0]  cpu_count = 4'd4;
   logic [31:0] rdata;
   logic        glob_en;
   logic        wake_all;
   logic        acc_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [31:0] g_rdata;
   logic        g_en, g_wake, g_err;

   always #2.5 clk = ~clk;

   irqdist_ctl_regs u0 (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
      .addr(addr), .wdata(wdata), .spi_count(spi_count), .cpu_count(cpu_count),
      .rdata(rdata), .glob_en(glob_en), .wake_all(wake_all), .acc_err(acc_err)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic acc(input logic rd, input logic wr, input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      rd_stb = rd; wr_stb = wr; addr = a; wdata = d;
      @(negedge clk);
      rd_stb = 1'b0; wr_stb = 1'b0; addr = 12'h0; wdata = 32'h0;
      g_rdata = rdata; g_en = glob_en; g_wake = wake_all; g_err = acc_err;
   endtask

   task automatic t_reset;
      chk("R1 enable", {31'h0, glob_en}, 32'h0);
      chk("R1 wake", {31'h0, wake_all}, 32'h0);
      chk("R1 err", {31'h0, acc_err}, 32'h0);
      chk("R1 rdata", rdata, 32'h0);
   endtask

   task automatic t_type;
      acc(1, 0, 12'h004, 0);
      chk("R5 type 64 lines 4 cpus", g_rdata, 32'h61);
      spi_count = 10'd224; cpu_count = 4'd1;
      acc(1, 0, 12'h004, 0);
      chk("R5 type 256 lines 1 cpu", g_rdata, 32'h07);
      spi_count = 10'd32; cpu_count = 4'd4;
   endtask

   task automatic t_id;
      acc(1, 0, 12'h008, 0);
      chk("R6 ident", g_rdata, 32'hA50003C1);
   endtask

   task automatic t_enable;
      acc(1, 0, 12'h000, 0);
      chk("R2 ctrl read clear", g_rdata, 32'h0);
      acc(0, 1, 12'h000, 32'h1);
      chk("R3 enable set", {31'h0, g_en}, 32'h1);
      chk("R4 wake on rise", {31'h0, g_wake}, 32'h1);
      @(negedge clk);
      chk("R4 wake one cycle", {31'h0, wake_all}, 32'h0);
      chk("R2 idle rdata", rdata, 32'h0);
      acc(1, 0, 12'h000, 0);
      chk("R2 ctrl read set", g_rdata, 32'h1);
      acc(0, 1, 12'h000, 32'hFFFF_FFFF);
      chk("R4 no wake when held", {31'h0, g_wake}, 32'h0);
      acc(0, 1, 12'h000, 32'h0);
      chk("R3 enable clear", {31'h0, g_en}, 32'h0);
      chk("R4 no wake on fall", {31'h0, g_wake}, 32'h0);
   endtask

   task automatic t_ignored;
      acc(0, 1, 12'h004, 32'hFFFF_FFFF);
      chk("R7 type write en", {31'h0, g_en}, 32'h0);
      chk("R7 type write wake", {31'h0, g_wake}, 32'h0);
      acc(1, 0, 12'h004, 0);
      chk("R7 type unchanged", g_rdata, 32'h61);
      acc(0, 1, 12'h008, 32'hFFFF_FFFF);
      chk("R7 ident write en", {31'h0, g_en}, 32'h0);
      acc(1, 0, 12'h008, 0);
      chk("R7 ident unchanged", g_rdata, 32'hA50003C1);
   endtask

   task automatic t_misalign;
      acc(0, 1, 12'h001, 32'h1);
      chk("R8 misaligned write err", {31'h0, g_err}, 32'h1);
      chk("R8 misaligned write en", {31'h0, g_en}, 32'h0);
      chk("R8 misaligned write wake", {31'h0, g_wake}, 32'h0);
      acc(1, 0, 12'h006, 0);
      chk("R8 misaligned read err", {31'h0, g_err}, 32'h1);
      chk("R8 misaligned read data", g_rdata, 32'h0);
   endtask

   task automatic rng(input logic [11:0] a, input logic exp_err);
      acc(1, 0, a, 0);
      chk($sformatf("R9 offset 0x%03h", a), {31'h0, g_err}, {31'h0, exp_err});
   endtask

   task automatic t_range;
      rng(12'h000, 0); rng(12'h00C, 1); rng(12'h07C, 1);
      rng(12'h080, 0); rng(12'h084, 0); rng(12'h088, 1);
      rng(12'h384, 0); rng(12'h388, 1);
      rng(12'h43C, 0); rng(12'h440, 1);
      rng(12'h83C, 0); rng(12'h840, 1);
      rng(12'hC0C, 0); rng(12'hC10, 1);
      rng(12'hF00, 0); rng(12'hF04, 1);
      rng(12'hF1C, 0); rng(12'hF2C, 0); rng(12'hF30, 1);
      acc(1, 0, 12'h080, 0);
      chk("R9 region read zero", g_rdata, 32'h0);
      spi_count = 10'd224;
      rng(12'h09C, 0); rng(12'h0A0, 1); rng(12'h4FC, 0);
      spi_count = 10'd32;
   endtask

   task automatic t_overlap;
      acc(1, 1, 12'h000, 32'h1);
      chk("R10 read old clear", g_rdata, 32'h0);
      chk("R10 write applied set", {31'h0, g_en}, 32'h1);
      chk("R10 wake same cycle", {31'h0, g_wake}, 32'h1);
      acc(1, 1, 12'h000, 32'h0);
      chk("R10 read old set", g_rdata, 32'h1);
      chk("R10 write applied clear", {31'h0, g_en}, 32'h0);
      chk("R10 no wake on clear", {31'h0, g_wake}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_type();
      t_id();
      t_enable();
      t_ignored();
      t_misalign();
      t_range();
      t_overlap();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule